// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate datapath. It holds three registers: a temporary operand register that supplies the first multiplicand, a 32-bit product register and a 32-bit accumulator. Each operation multiplies the temporary register by the operand presented on the input port. Every operand is a signed two's complement value. Depending on the opcode, the result goes into the product register alone, directly into the accumulator, or into the accumulator and product register together as one 64-bit destination. In that last case the upper word goes to the accumulator.

The accumulator adder can take the product register or the fresh multiplier output as its second input. An opcode can therefore add the previous product into the accumulator while the new product is captured in the same cycle. A dual mode splits both operands into signed 16-bit halves and performs two multiply-accumulates at once. The high-half product is added into the accumulator and the low-half product is added into the product register. Each accepted operation updates the registers at the clock edge where it is sampled, and pulses a done output in the following cycle. An overflow flag reports signed wrap of a 32-bit accumulator addition.

Top module: `dual_mac_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the accumulator, product register, done and overflow flag read zero, and the temporary register holds zero.
- R2: When loadTemp is high at a clock edge, the temporary register takes tempIn. An operation sampled at that same edge uses the value the temporary register held before the load.
- R3: Opcode 0 writes the low 32 bits of the signed product temp*operand into the product register and leaves the accumulator unchanged.
- R4: Opcode 1 writes the low 32 bits of the signed product into the accumulator and leaves the product register unchanged.
- R5: Opcode 2 writes the full signed 64-bit product across the two registers: bits 63:32 go to the accumulator and bits 31:0 go to the product register.
- R6: Opcode 3 adds the product register's previous value to the accumulator, and in the same cycle loads the low 32 bits of the new product into the product register.
- R7: Opcode 4 adds the low 32 bits of the new product to the accumulator and leaves the product register unchanged.
- R8: Opcode 5 is dual mode. The accumulator gains temp[31:16]*operand[31:16], and the product register gains temp[15:0]*operand[15:0], with each half treated as signed 16-bit and each product as signed 32-bit. Both additions wrap modulo 2^32.
- R9: After opcodes 3, 4 and 5, the overflow flag is 1 exactly when the signed 32-bit accumulator addition left the range -2^31..2^31-1. After opcodes 0, 1, 2 and 6 the flag is 0. In every other case it holds its value.
- R10: Opcode 6 clears the accumulator and the product register.
- R11: Opcode 7 is reserved. It changes neither the accumulator, the product register nor the overflow flag, and it produces no done pulse.
- R12: done is high for exactly the one cycle after an edge at which opValid was high with an opcode other than 7. When opValid is low, the accumulator and product register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| loadTemp | input | 1 | Load strobe for the temporary operand register |
| tempIn | input | 32 | Value loaded into the temporary register |
| operand | input | 32 | Second multiplicand |
| opValid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation select (see R3 to R11) |
| accOut | output | 32 | Accumulator |
| prodOut | output | 32 | Product register |
| done | output | 1 | One-cycle completion pulse |
| ovfFlag | output | 1 | Accumulator signed-overflow flag |

## Verification
Two same-cycle interactions are targeted. The first is a temporary-register load in the cycle that an operation is sampled. The bench drives loadTemp and opValid together and expects the product to be formed from the old temporary value. The second is opcode 3, which reads the product register while overwriting it. The bench runs several of these back to back and expects each accumulation to use the product from the previous cycle. A behavioural model with 64-bit integers is compared against every output on every clock. This also covers a long pseudo-random run of mixed opcodes with random loads.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL_P    = 3'd0,
    OP_MUL_ACC  = 3'd1,
    OP_MUL_WIDE = 3'd2,
    OP_MAC      = 3'd3,
    OP_ADD_PROD = 3'd4,
    OP_DUAL     = 3'd5,
    OP_CLEAR    = 3'd6,
    OP_RSVD     = 3'd7
  } macOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic prodToP;
    logic lowToAcc;
    logic highToAcc;
    logic accAddP;
    logic accAddProd;
    logic dualMac;
    logic clearAll;
    logic legal;
  } macCtl_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opcode,
  output macCtl_t    ctl,
  output logic       done
);
  always_comb begin
    ctl = '0;
    if (opValid) begin
      case (macOp_e'(opcode))
        OP_MUL_P:    begin ctl.prodToP = 1'b1; ctl.legal = 1'b1; end
        OP_MUL_ACC:  begin ctl.lowToAcc = 1'b1; ctl.legal = 1'b1; end
        OP_MUL_WIDE: begin ctl.highToAcc = 1'b1; ctl.prodToP = 1'b1; ctl.legal = 1'b1; end
        OP_MAC:      begin ctl.accAddP = 1'b1; ctl.prodToP = 1'b1; ctl.legal = 1'b1; end
        OP_ADD_PROD: begin ctl.accAddProd = 1'b1; ctl.legal = 1'b1; end
        OP_DUAL:     begin ctl.dualMac = 1'b1; ctl.legal = 1'b1; end
        OP_CLEAR:    begin ctl.clearAll = 1'b1; ctl.legal = 1'b1; end
        default:     ctl = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= ctl.legal;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadTemp,
  input  logic [DATA_W-1:0] tempIn,
  input  logic [DATA_W-1:0] operand,
  input  macCtl_t           ctl,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] prodOut,
  output logic              ovfFlag
);
  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] tempReg, accReg, prodReg;
  logic              ovfReg;

  logic signed [DATA_W-1:0] tempS, opS;
  logic signed [WIDE_W-1:0] fullProd;
  logic signed [DATA_W-1:0] laneProd [LANES];

  assign tempS    = tempReg;
  assign opS      = operand;
  assign fullProd = tempS * opS;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [HALF_W-1:0] laneA, laneB;
    assign laneA       = tempReg[g*HALF_W +: HALF_W];
    assign laneB       = operand[g*HALF_W +: HALF_W];
    assign laneProd[g] = laneA * laneB;
  end

  // accumulator adder: second input from P, the multiplier, or the high lane
  logic [DATA_W-1:0] addend, accSum;
  logic              adding, sumOvf;

  always_comb begin
    if (ctl.accAddP)         addend = prodReg;
    else if (ctl.accAddProd) addend = fullProd[DATA_W-1:0];
    else if (ctl.dualMac)    addend = laneProd[1];
    else                     addend = '0;
  end

  assign adding = ctl.accAddP | ctl.accAddProd | ctl.dualMac;
  assign accSum = accReg + addend;
  assign sumOvf = (accReg[DATA_W-1] == addend[DATA_W-1]) &&
                  (accSum[DATA_W-1] != accReg[DATA_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempReg <= '0;
      accReg  <= '0;
      prodReg <= '0;
      ovfReg  <= 1'b0;
    end else begin
      if (loadTemp) tempReg <= tempIn;

      if (ctl.clearAll) begin
        accReg  <= '0;
        prodReg <= '0;
      end
      if (ctl.lowToAcc)  accReg <= fullProd[DATA_W-1:0];
      if (ctl.highToAcc) accReg <= fullProd[WIDE_W-1:DATA_W];
      if (adding)        accReg <= accSum;

      if (ctl.prodToP) prodReg <= fullProd[DATA_W-1:0];
      if (ctl.dualMac) prodReg <= prodReg + laneProd[0];

      if (ctl.legal) ovfReg <= adding ? sumOvf : 1'b0;
    end
  end

  assign accOut  = accReg;
  assign prodOut = prodReg;
  assign ovfFlag = ovfReg;
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadTemp,
  input  logic [DATA_W-1:0] tempIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              opValid,
  input  logic [2:0]        opcode,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] prodOut,
  output logic              done,
  output logic              ovfFlag
);
  macCtl_t ctl;

  mac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opcode  (opcode),
    .ctl     (ctl),
    .done    (done)
  );

  mac_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .loadTemp (loadTemp),
    .tempIn   (tempIn),
    .operand  (operand),
    .ctl      (ctl),
    .accOut   (accOut),
    .prodOut  (prodOut),
    .ovfFlag  (ovfFlag)
  );
endmodule

// File: rtl/dual_mac_unit_chk.sv
module dual_mac_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] prodOut,
  input logic              done,
  input logic              ovfFlag
);
  assert_done_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode != 3'd7) |=> done);

  assert_no_spurious_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opcode != 3'd7) |=> !done);

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(accOut) && $stable(prodOut)));

  assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == 3'd7) |=> ($stable(accOut) && $stable(prodOut) && $stable(ovfFlag)));

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == 3'd6) |=> (accOut == '0 && prodOut == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opcode == 3'd0 || opcode == 3'd1 || opcode == 3'd2 || opcode == 3'd6))
      |=> !ovfFlag);

  assert_mul_p_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == 3'd0) |=> $stable(accOut));

  assert_mul_acc_keeps_p_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == 3'd1) |=> $stable(prodOut));
endmodule

bind dual_mac_unit dual_mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opcode  (opcode),
  .accOut  (accOut),
  .prodOut (prodOut),
  .done    (done),
  .ovfFlag (ovfFlag)
);

// File: tb/dual_mac_unit_tb.sv
module dual_mac_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadTemp = 1'b0;
  logic [31:0] tempIn = '0;
  logic [31:0] operand = '0;
  logic        opValid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [31:0] accOut, prodOut;
  logic        done, ovfFlag;

  int total = 0;
  int bad = 0;

  // reference state
  logic [31:0] mXt = '0, mAcc = '0, mP = '0;
  logic        mDone = 1'b0, mOvf = 1'b0;
  string       lastTag = "R1";

  always #2 clk = ~clk;

  dual_mac_unit u_dut (
    .clk(clk), .rstN(rstN), .loadTemp(loadTemp), .tempIn(tempIn),
    .operand(operand), .opValid(opValid), .opcode(opcode),
    .accOut(accOut), .prodOut(prodOut), .done(done), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic wraps(input longint wide);
    longint top;
    top = wide >>> 31;
    return (top != 0) && (top != -1);
  endfunction

  task automatic modelAdvance(input logic ld, input logic [31:0] tv, input logic v,
                              input logic [2:0] op, input logic [31:0] opd);
    longint full, hiP, loP, wide;
    logic [31:0] add32;
    full = longint'($signed(mXt)) * longint'($signed(opd));
    hiP  = longint'($signed(mXt[31:16])) * longint'($signed(opd[31:16]));
    loP  = longint'($signed(mXt[15:0])) * longint'($signed(opd[15:0]));
    mDone = v && (op != 3'd7);
    if (v) begin
      case (op)
        3'd0: begin mP = full[31:0]; mOvf = 1'b0; end
        3'd1: begin mAcc = full[31:0]; mOvf = 1'b0; end
        3'd2: begin mAcc = full[63:32]; mP = full[31:0]; mOvf = 1'b0; end
        3'd3, 3'd4, 3'd5: begin
          if (op == 3'd3)      add32 = mP;
          else if (op == 3'd4) add32 = full[31:0];
          else                 add32 = hiP[31:0];
          wide = longint'($signed(mAcc)) + longint'($signed(add32));
          mOvf = wraps(wide);
          mAcc = wide[31:0];
          if (op == 3'd3) mP = full[31:0];
          if (op == 3'd5) mP = mP + loP[31:0];
        end
        3'd6: begin mAcc = '0; mP = '0; mOvf = 1'b0; end
        default: ;
      endcase
    end
    if (ld) mXt = tv;
  endtask

  // one clock: compare the result of the previous edge, then drive the next stimulus
  task automatic step(input logic ld, input logic [31:0] tv, input logic v,
                      input logic [2:0] op, input logic [31:0] opd, input string tag);
    @(negedge clk);
    chk(lastTag, "acc", accOut, mAcc);
    chk(lastTag, "prod", prodOut, mP);
    chk(lastTag, "done", {31'd0, done}, {31'd0, mDone});
    chk(lastTag, "ovf", {31'd0, ovfFlag}, {31'd0, mOvf});
    loadTemp = ld; tempIn = tv; opValid = v; opcode = op; operand = opd;
    modelAdvance(ld, tv, v, op, opd);
    lastTag = tag;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "acc in reset", accOut, 32'd0);
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;

    // R1 then R2: load temp with no operation
    step(1, 32'd7, 0, 3'd0, 32'd0, "R2");
    // R3: P <= 7 * -3
    step(0, 32'd0, 1, 3'd0, 32'hFFFF_FFFD, "R3");
    // R2: load and operate together; the product uses the old temp value (7)
    step(1, 32'hFFFF_FFFB, 1, 3'd1, 32'd1000, "R2");
    // R4: ACC <= -5 * 3
    step(0, 32'd0, 1, 3'd1, 32'd3, "R4");
    // R5: 64-bit product across ACC:P
    step(1, 32'h1234_5678, 0, 3'd0, 32'd0, "R2");
    step(0, 32'd0, 1, 3'd2, 32'h9ABC_DEF0, "R5");
    step(1, 32'h8000_0000, 0, 3'd0, 32'd0, "R2");
    step(0, 32'd0, 1, 3'd2, 32'h8000_0000, "R5");
    // R6: back-to-back MAC, each adds the previous P
    step(1, 32'd11, 1, 3'd6, 32'd0, "R10");
    step(0, 32'd0, 1, 3'd0, 32'd2, "R3");
    step(0, 32'd0, 1, 3'd3, 32'd5, "R6");
    step(0, 32'd0, 1, 3'd3, 32'hFFFF_FFF0, "R6");
    step(0, 32'd0, 1, 3'd3, 32'd9, "R6");
    // R7: add the new product
    step(0, 32'd0, 1, 3'd4, 32'd100, "R7");
    // R9: positive wrap, then negative wrap, then a clean add
    step(1, 32'h4000_0000, 1, 3'd6, 32'd0, "R10");
    step(0, 32'd0, 1, 3'd1, 32'd1, "R4");
    step(0, 32'd0, 1, 3'd4, 32'd1, "R9");
    step(0, 32'd0, 1, 3'd4, 32'hFFFF_FFFF, "R9");
    step(0, 32'd0, 0, 3'd0, 32'd0, "R9");
    step(0, 32'd0, 1, 3'd4, 32'd0, "R9");
    step(0, 32'd0, 1, 3'd1, 32'd1, "R9");
    // R8: dual lanes, signed halves
    step(1, {16'hFFFE, 16'h0003}, 1, 3'd6, 32'd0, "R10");
    step(0, 32'd0, 1, 3'd5, {16'h0005, 16'hFFF9}, "R8");
    step(0, 32'd0, 1, 3'd5, {16'h8000, 16'h8000}, "R8");
    step(1, {16'h8000, 16'h8000}, 0, 3'd0, 32'd0, "R2");
    step(0, 32'd0, 1, 3'd5, {16'h8000, 16'h8000}, "R8");
    step(0, 32'd0, 1, 3'd5, {16'h8000, 16'h8000}, "R8");
    // R11: reserved opcode changes nothing, no done
    step(0, 32'd0, 1, 3'd7, 32'h1234_5678, "R11");
    step(0, 32'd0, 1, 3'd7, 32'hFFFF_FFFF, "R11");
    // R12: idle cycles keep state, done drops
    step(0, 32'd0, 0, 3'd3, 32'd77, "R12");
    step(0, 32'd0, 0, 3'd2, 32'd5, "R12");
    // R10: clear
    step(0, 32'd0, 1, 3'd6, 32'd0, "R10");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic       v, ld;
      op = 3'($urandom_range(0, 7));
      v  = ($urandom_range(0, 3) != 0);
      ld = ($urandom_range(0, 2) == 0);
      step(ld, $urandom, v, op, $urandom, v ? tagOf(op) : "R12");
    end
    step(0, 32'd0, 0, 3'd0, 32'd0, "R12");
    step(0, 32'd0, 0, 3'd0, 32'd0, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule